// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block runs the timing of a dual-slope integrating analogue-to-digital conversion. On a start request it closes the integrator-reset switch for a programmed number of clocks. It then routes the unknown input to the integrator and waits for the comparator to report that the integrator output has passed a small, stable threshold. That crossing starts a run-up of exactly M clocks. The sequencer then switches the integrator to the reference and counts clocks until the comparator reports the crossing back. That count is N, and the input equals the reference scaled by N/M. The block reports N and M together in a single done cycle. Because a bias current keeps the integrator moving even with no input, a zero input still gives a finite, nonzero N. Offset and gain are removed later by calibration outside this block.

M is programmable, so the run-up can be set to a whole number of periods of a known interfering frequency, for example mains ripple. That component then integrates to zero. A programmable timeout guards both comparator waits, so a missing crossing ends in an error pulse instead of a hang. The three switch controls are decoded from a registered state. They are never closed together, and every change from one switch to another passes through at least one clock with all switches open.

States: IDLE, ZERO (reset switch closed), GAP_IN (all open), WAIT_X (input connected, waiting for the crossing), RUNUP (input connected, M clocks), GAP_REF (all open), RUNDOWN (reference connected, counting N), DONE, FAULT. Transitions: IDLE→ZERO on start; ZERO→GAP_IN when the zero length ends; GAP_IN→WAIT_X; WAIT_X→RUNUP on the crossing or WAIT_X→FAULT on timeout; RUNUP→GAP_REF after M clocks; GAP_REF→RUNDOWN; RUNDOWN→DONE on the crossing back or RUNDOWN→FAULT on timeout; DONE→IDLE and FAULT→IDLE.

Top module: `dslope_seq`

## Requirements
- R1: During and right after reset, all three switch outputs, `busy`, `done` and `error` are low, and `result_n` and `result_m` are zero.
- R2: A `start` sampled high in IDLE latches the three configuration inputs. From the next clock, `sw_zero` is high for exactly max(`cfg_zero_len`,1) cycles.
- R3: At most one switch output is high in any cycle. Between a cycle with one switch high and a cycle with a different switch high, there is at least one cycle with all switches low.
- R4: After one all-open cycle, `sw_input` goes high and stays high through the wait for `cmp_above`=1. Counting from the first clock edge that samples `cmp_above`=1, it stays high for exactly M = max(latched `cfg_runup_len`,1) more cycles.
- R5: After one all-open cycle, `sw_ref` goes high. N is the number of clock edges in this phase that sample `cmp_above`=1 before the first edge that samples it 0. `sw_ref` goes low after that edge.
- R6: A normal end gives a one-cycle `done` pulse with all switches open. In that cycle, `result_n` = N and `result_m` = the latched run-up setting. Both hold those values until the next `done`, and the block then returns to IDLE.
- R7: If the wait for the first crossing sees `cmp_above`=0 on T consecutive edges (T = max(latched `cfg_timeout`,1)), `sw_input` opens after T cycles. The block then gives a one-cycle `error` pulse, leaves both results unchanged and returns to IDLE.
- R8: If the run-down samples `cmp_above`=1 on T edges, `sw_ref` opens after T cycles and the block gives a one-cycle `error` pulse with the results unchanged. A run-down with exactly T-1 high samples completes normally with N = T-1.
- R9: `start` and all configuration inputs are ignored while a conversion is in progress. The phase lengths and `result_m` follow the values latched at start.
- R10: `busy` is high in every cycle from the clock after an accepted start through the `done` or `error` cycle, and low in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, sampled in IDLE |
| cmp_above | input | 1 | Comparator: 1 while the integrator is beyond the threshold level |
| cfg_zero_len | input | ZERO_W | Integrator reset length in clocks |
| cfg_runup_len | input | CNT_W | Run-up length M in clocks |
| cfg_timeout | input | CNT_W | Limit for each comparator wait, in clocks |
| sw_zero | output | 1 | Integrator reset switch control |
| sw_input | output | 1 | Input switch control |
| sw_ref | output | 1 | Reference switch control |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: results valid |
| error | output | 1 | One-cycle pulse: timeout abort |
| result_n | output | CNT_W | Run-down count N |
| result_m | output | CNT_W | Run-up count M used |

## Verification
The bench models the integrator and comparator. It holds `cmp_above` low for a chosen number of input cycles, then high until the reference has been connected for a chosen number of cycles. From those settings it predicts every phase length and result. The corner cases it targets are the following:
- Zero settings treated as one. A design that mishandles them would stall or skip a phase.
- A crossing on the very first run-down edge, which gives N=0. An off-by-one design would report 1.
- Both timeouts exactly at their limit and one count below it. A design with the wrong comparison would abort a valid conversion or report a count beyond the limit.
- `start` and a run-up change injected mid-conversion. A design that fails to latch its settings would restart or stretch the run-up.

A fault that leaves stale results changed, or switches that overlap or change without an open cycle, also shows up directly in the counts.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ZERO,
        ST_GAP_IN,
        ST_WAIT_X,
        ST_RUNUP,
        ST_GAP_REF,
        ST_RUNDOWN,
        ST_DONE,
        ST_FAULT
    } seq_state_t;

endpackage

// File: rtl/dslope_tally.sv
// Saturating cycle counter with a terminal flag against a limit.
module dslope_tally #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         at_last
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en && count != MAXV) begin
            count <= count + 1'b1;
        end
    end

    // The current cycle is the last one when count+1 reaches the limit;
    // a limit of zero behaves like one.
    always_comb begin
        at_last = ({1'b0, count} + 1'b1) >= {1'b0, limit};
    end

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ZERO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_above,
    input  logic [ZERO_W-1:0] cfg_zero_len,
    input  logic [CNT_W-1:0]  cfg_runup_len,
    input  logic [CNT_W-1:0]  cfg_timeout,
    output logic              sw_zero,
    output logic              sw_input,
    output logic              sw_ref,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [CNT_W-1:0]  result_n,
    output logic [CNT_W-1:0]  result_m
);

    seq_state_t state_q, state_d;

    logic [ZERO_W-1:0] zero_len_q;
    logic [CNT_W-1:0]  runup_q;
    logic [CNT_W-1:0]  timeout_q;

    logic [CNT_W-1:0]  ph_limit;
    logic [CNT_W-1:0]  ph_count;
    logic              ph_last;
    logic              ph_clr;

    logic [CNT_W-1:0]  rd_count;
    logic              rd_last;
    logic              rd_clr;
    logic              rd_en;

    logic              accept;

    assign accept = (state_q == ST_IDLE) && start;

    // Settings are frozen at the accepted start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_len_q <= '0;
            runup_q    <= '0;
            timeout_q  <= '0;
        end else if (accept) begin
            zero_len_q <= cfg_zero_len;
            runup_q    <= cfg_runup_len;
            timeout_q  <= cfg_timeout;
        end
    end

    // Phase timer limit: one counter serves reset, wait and run-up.
    always_comb begin
        unique case (state_q)
            ST_ZERO:  ph_limit = CNT_W'(zero_len_q);
            ST_WAIT_X: ph_limit = timeout_q;
            ST_RUNUP: ph_limit = runup_q;
            default:  ph_limit = '0;
        endcase
    end

    assign ph_clr = (state_d != state_q);

    dslope_tally #(.W(CNT_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ph_clr),
        .en      (1'b1),
        .limit   (ph_limit),
        .count   (ph_count),
        .at_last (ph_last)
    );

    // Run-down counter: counts edges with the comparator still high.
    assign rd_clr = (state_q != ST_RUNDOWN);
    assign rd_en  = (state_q == ST_RUNDOWN) && cmp_above;

    dslope_tally #(.W(CNT_W)) u_rundown (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rd_clr),
        .en      (rd_en),
        .limit   (timeout_q),
        .count   (rd_count),
        .at_last (rd_last)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_ZERO;
            ST_ZERO:    if (ph_last) state_d = ST_GAP_IN;
            ST_GAP_IN:  state_d = ST_WAIT_X;
            ST_WAIT_X: begin
                if (cmp_above)    state_d = ST_RUNUP;
                else if (ph_last) state_d = ST_FAULT;
            end
            ST_RUNUP:   if (ph_last) state_d = ST_GAP_REF;
            ST_GAP_REF: state_d = ST_RUNDOWN;
            ST_RUNDOWN: begin
                if (!cmp_above)   state_d = ST_DONE;
                else if (rd_last) state_d = ST_FAULT;
            end
            ST_DONE:    state_d = ST_IDLE;
            ST_FAULT:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Result registers, loaded on the edge that enters DONE.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_n <= '0;
            result_m <= '0;
        end else if (state_q == ST_RUNDOWN && !cmp_above) begin
            result_n <= rd_count;
            result_m <= runup_q;
        end
    end

    // Outputs decoded from the registered state only.
    always_comb begin
        sw_zero  = 1'b0;
        sw_input = 1'b0;
        sw_ref   = 1'b0;
        done     = 1'b0;
        error    = 1'b0;
        busy     = (state_q != ST_IDLE);
        unique case (state_q)
            ST_ZERO:    sw_zero  = 1'b1;
            ST_WAIT_X:  sw_input = 1'b1;
            ST_RUNUP:   sw_input = 1'b1;
            ST_RUNDOWN: sw_ref   = 1'b1;
            ST_DONE:    done     = 1'b1;
            ST_FAULT:   error    = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         sw_zero,
    input logic         sw_input,
    input logic         sw_ref,
    input logic         busy,
    input logic         done,
    input logic         error,
    input logic [W-1:0] result_n,
    input logic [W-1:0] result_m
);

    logic any_sw;
    assign any_sw = sw_zero | sw_input | sw_ref;

    a_r3_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sw_zero, sw_input, sw_ref}));

    a_r3_gap_input: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_input) |-> $past(!any_sw));

    a_r3_gap_ref: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ref) |-> $past(!any_sw));

    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && sw_zero));

    a_r5_ref_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_ref) |-> (done || error));

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_done_open: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !any_sw);

    a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(result_n) && $stable(result_m)) |-> done);

    a_r7_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);

    a_r7_not_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    a_r10_idle_open: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!any_sw && !done && !error));

endmodule

bind dslope_seq dslope_seq_chk #(.W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sw_zero  (sw_zero),
    .sw_input (sw_input),
    .sw_ref   (sw_ref),
    .busy     (busy),
    .done     (done),
    .error    (error),
    .result_n (result_n),
    .result_m (result_m)
);

// File: tb/dslope_seq_tb.sv
`timescale 1ns/1ps
module dslope_seq_tb;

    localparam int CNT_W  = 16;
    localparam int ZERO_W = 8;
    localparam int NVEC   = 8;

    // Fields: zero_len, runup, timeout, wait cycles D, rundown cycles R,
    // expected kind (0 done, 1 wait timeout, 2 rundown timeout), expected N
    localparam int VEC [NVEC][7] = '{
        '{4,  10,  50, 3,  20, 0, 19},
        '{0,   1,  50, 1,   1, 0,  0},
        '{1,  60, 100, 7,  85, 0, 84},
        '{3,   8,   5, 6,  10, 1,  0},
        '{2,   8,   5, 5,  10, 2,  0},
        '{2,   8,   9, 5,  10, 2,  0},
        '{2,   8,  10, 5,  10, 0,  9},
        '{5, 200, 300, 2, 150, 0, 149}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              cmp_above = 1'b0;
    logic [ZERO_W-1:0] cfg_zero_len = '0;
    logic [CNT_W-1:0]  cfg_runup_len = '0;
    logic [CNT_W-1:0]  cfg_timeout = '0;
    logic              sw_zero, sw_input, sw_ref, busy, done, error;
    logic [CNT_W-1:0]  result_n, result_m;

    int n_checks = 0;
    int n_errors = 0;
    int last_n = 0;
    int last_m = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dslope_seq #(.CNT_W(CNT_W), .ZERO_W(ZERO_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .cmp_above     (cmp_above),
        .cfg_zero_len  (cfg_zero_len),
        .cfg_runup_len (cfg_runup_len),
        .cfg_timeout   (cfg_timeout),
        .sw_zero       (sw_zero),
        .sw_input      (sw_input),
        .sw_ref        (sw_ref),
        .busy          (busy),
        .done          (done),
        .error         (error),
        .result_n      (result_n),
        .result_m      (result_m)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_conv(input int z, input int m, input int to, input int d,
                            input int r, input int kind, input int exp_n,
                            input bit disturb);
        int zero_c = 0, in_c = 0, ref_c = 0, bad_sw = 0, idle_in_run = 0;
        int got_done = 0, got_err = 0, cap_n = 0, cap_m = 0;
        int exp_z, exp_in, exp_ref, exp_t;
        logic [2:0] prev_sw = 3'b000;
        logic [2:0] cur_sw;
        exp_z = (z == 0) ? 1 : z;
        exp_t = (to == 0) ? 1 : to;
        exp_in  = (kind == 1) ? exp_t : d + m;
        exp_ref = (kind == 1) ? 0 : ((kind == 2) ? exp_t : r);
        cfg_zero_len  = ZERO_W'(z);
        cfg_runup_len = CNT_W'(m);
        cfg_timeout   = CNT_W'(to);
        cmp_above = 1'b0;
        @(negedge clk);
        start = 1'b1;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            cur_sw = {sw_zero, sw_input, sw_ref};
            if ($countones(cur_sw) > 1) bad_sw++;
            if (cur_sw != 3'b000 && prev_sw != 3'b000 && cur_sw != prev_sw) bad_sw++;
            prev_sw = cur_sw;
            if (!busy) idle_in_run++;
            if (sw_zero) zero_c++;
            if (sw_input) begin
                in_c++;
                if (in_c >= d) cmp_above = 1'b1;
                if (disturb && in_c == 3) begin
                    start = 1'b1;
                    cfg_runup_len = CNT_W'(m + 7);
                    cfg_zero_len  = ZERO_W'(z + 3);
                end
            end
            if (sw_ref) begin
                ref_c++;
                if (ref_c >= r) cmp_above = 1'b0;
            end
            if (done) begin got_done++; cap_n = int'(result_n); cap_m = int'(result_m); end
            if (error) begin got_err++; cap_n = int'(result_n); cap_m = int'(result_m); end
            if (done || error) break;
        end
        chk("R2", "zero switch cycles", zero_c, exp_z);
        chk("R4", "input switch cycles", in_c, exp_in);
        chk("R5", "reference switch cycles", ref_c, exp_ref);
        chk("R3", "switch overlap or missing gap", bad_sw, 0);
        chk("R10", "busy low inside conversion", idle_in_run, 0);
        if (kind == 0) begin
            chk("R6", "done pulse", got_done, 1);
            chk("R6", "result_n", cap_n, exp_n);
            chk("R6", "result_m", cap_m, m);
            last_n = exp_n;
            last_m = m;
        end else begin
            chk(kind == 1 ? "R7" : "R8", "error pulse", got_err, 1);
            chk(kind == 1 ? "R7" : "R8", "done on timeout", got_done, 0);
            chk("R7", "result_n held on fault", cap_n, last_n);
            chk("R7", "result_m held on fault", cap_m, last_m);
        end
        @(negedge clk);
        chk("R6", "back to idle", int'(busy), 0);
        chk("R6", "done dropped", int'(done), 0);
        chk("R7", "error dropped", int'(error), 0);
        if (disturb) begin
            int restarted = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (sw_zero || busy) restarted++;
            end
            chk("R9", "start during run caused restart", restarted, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "switches in reset", int'({sw_zero, sw_input, sw_ref}), 0);
        chk("R1", "busy/done/error in reset", int'({busy, done, error}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "switches after reset", int'({sw_zero, sw_input, sw_ref}), 0);
        chk("R1", "flags after reset", int'({busy, done, error}), 0);
        chk("R1", "result_n after reset", int'(result_n), 0);
        chk("R1", "result_m after reset", int'(result_m), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_conv(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4],
                     VEC[v][5], VEC[v][6], 1'b0);
        end

        // R9: start and run-up change during a conversion are ignored
        run_conv(2, 12, 40, 4, 6, 0, 5, 1'b1);

        // R8 boundary: one high sample short of the limit completes
        run_conv(1, 3, 4, 1, 4, 0, 3, 1'b0);

        // R10: idle with start low stays idle
        repeat (5) @(negedge clk);
        chk("R10", "busy in idle", int'(busy), 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule